// File: doc/BRIEF.md
# MDIO Management Master with Background Link Polling

This block is the management-side master of a two-wire MDIO bus. A host writes one command register that holds a PHY address, a register address, a command code and a 16-bit data word, and sets the start/busy flag in that same register. The block then sends the matching read or write frame on MDC/MDIO. The flag stays set until the frame has fully ended, so software learns of completion by polling it. For a read, the received word replaces the data field before the flag drops.

When background polling is enabled, the block keeps reading the basic status register (register 1) of one configured PHY whenever the host is not using the bus. It keeps the last link bit it saw and latches a sticky link-change flag whenever a new sample differs from that stored bit. A host command that arrives during a poll frame waits for that frame to end and then goes ahead of the next poll. Two sticky event flags, link change and host-transaction done, are each gated by an enable register to form one interrupt line.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0. MDC is low, MDIO output enable is low, MDIO out is 1 and the interrupt is low.
- R2: A command write with code 1 and start (bit 28) set sends one 64-bit frame, MSB first, with output enable high for all 64 bits. The frame is 32 ones, then 01, then opcode 01, PHY address (bits 25:21), register address (bits 20:16), turnaround 10, and the 16 data bits (bits 15:0).
- R3: Code 2 sends the same header with opcode 10. Output enable is low from the first turnaround bit to the end of the frame. The 16 bits sampled in the data phase are written into bits 15:0 of the command register before start/busy clears.
- R4: Start/busy (bit 28) reads 1 from the command write until the frame ends. Writes to the command register while it is 1 are ignored.
- R5: A start with code 0 or 3 sends no frame, and start/busy reads 0 straight away.
- R6: MDC toggles every CLK_DIV clock cycles, starting from reset. MDIO out and output enable change only in the cycle in which MDC falls.
- R7: With polling on (mode bit 0), the block reads register 1 of the PHY at mode bits 5:1. Received bit 2 is stored and shown at status bit 2. A sample that differs from the stored value (0 after reset) sets status bit 12.
- R8: Writing 1 to status bit 12 or status bit 0 clears that bit. Writing 0 leaves it unchanged.
- R9: Status bit 0 is set when a host transaction (code 1 or 2) ends.
- R10: The interrupt output is high exactly when (enable bit 12 and status bit 12) or (enable bit 0 and status bit 0) is true. With the enable register at 0 it stays low.
- R11: A host command written while a poll frame is in flight is the next frame sent after that poll frame.
- R12: After polling is cleared, the frame in flight finishes within (64+2)*2*CLK_DIV+8 cycles and no further poll frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 command, 1 mode, 2 status, 3 event enable |
| reg_wdata_i | input | 29 | Register write data |
| reg_rdata_o | output | 29 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| irq_o | output | 1 | Gated event interrupt |

## Verification
The bench builds the block with CLK_DIV = 2. That gives an MDC period of four clocks and a frame of about 260 cycles. At that length many frames fit in a short run, so the bench can reach back-to-back polls, a host command landing mid-poll, the link bit toggling in both directions and polling being switched off mid-frame. A behavioural PHY decodes every frame from the pins and answers reads. A clock-by-clock model checks the MDC phase and when MDIO is allowed to change.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int REG_W     = 29;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_MODE = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_EVEN = 2'd3;

  localparam int CMD_START = 28;
  localparam int CMD_CODE  = 26;
  localparam int CMD_PHY   = 21;
  localparam int CMD_REG   = 16;
  localparam int ST_DONE   = 0;
  localparam int ST_LINK   = 2;
  localparam int ST_LCHG   = 12;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [1:0] op, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg, input logic [DATA_W-1:0] data);
    logic [1:0] ta;
    ta = (op == OP_RD) ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_MAX);
  assign rise_o = wrap && !mdc_o;
  assign fall_o = wrap && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= !mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 start_i,
  input  logic                 rd_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic                 active_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int POS_W = $clog2(FRAME_LEN + 1);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(FRAME_LEN);
  localparam logic [POS_W-1:0] POS_TA   = POS_W'(TA_IDX);
  localparam logic [POS_W-1:0] POS_SAMP = POS_W'(DATA_IDX + 1);

  logic [FRAME_LEN-1:0] sh_q;
  logic [POS_W-1:0]     pos_q;
  logic                 rd_q;
  logic                 driving;

  assign driving = active_o && (pos_q < POS_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      pos_q     <= '0;
      rd_q      <= 1'b0;
      active_o  <= 1'b0;
      done_o    <= 1'b0;
      rdata_o   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_o) begin
        active_o <= 1'b1;
        rd_q     <= rd_i;
        sh_q     <= frame_i;
        pos_q    <= '0;
      end else if (active_o) begin
        if (fall_i && driving) begin
          mdio_o    <= sh_q[FRAME_LEN-1];
          mdio_oe_o <= !(rd_q && (pos_q >= POS_TA));
          sh_q      <= sh_q << 1;
          pos_q     <= pos_q + 1'b1;
        end
        // bit b driven at a fall is sampled at the next rise (pos = b+1)
        if (rise_i && (pos_q != '0)) begin
          if (rd_q && (pos_q >= POS_SAMP)) rdata_o <= {rdata_o[DATA_W-2:0], mdio_i};
          if (pos_q == POS_END) begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
          end
        end
      end
      if (fall_i && !driving) begin
        mdio_o    <= 1'b1;
        mdio_oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic             irq_o
);
  logic rise, fall;
  logic f_active, f_done, f_start, f_rd;
  logic [FRAME_LEN-1:0] f_frame;
  logic [DATA_W-1:0]    f_rdata;

  logic                busy_q, own_host_q;
  logic [1:0]          code_q;
  logic [ADDR_W-1:0]   phy_q, regad_q, poll_phy_q;
  logic [DATA_W-1:0]   data_q;
  logic                poll_en_q, link_q, lchg_q, done_q, lchg_en_q, done_en_q;
  logic                wr_cmd, wr_mode, wr_stat, wr_even, sel_host;
  logic [1:0]          new_code;

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall));

  assign sel_host = busy_q;
  assign f_start  = !f_active && !f_done && (busy_q || poll_en_q);
  assign f_rd     = sel_host ? (code_q == OP_RD) : 1'b1;
  assign f_frame  = sel_host ? build_frame(code_q, phy_q, regad_q, data_q)
                             : build_frame(OP_RD, poll_phy_q, ADDR_W'(1), '0);

  mdio_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .start_i(f_start), .rd_i(f_rd), .frame_i(f_frame), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .active_o(f_active),
    .done_o(f_done), .rdata_o(f_rdata));

  assign wr_cmd   = reg_wr_i && (reg_addr_i == RA_CMD);
  assign wr_mode  = reg_wr_i && (reg_addr_i == RA_MODE);
  assign wr_stat  = reg_wr_i && (reg_addr_i == RA_STAT);
  assign wr_even  = reg_wr_i && (reg_addr_i == RA_EVEN);
  assign new_code = reg_wdata_i[CMD_CODE+:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; own_host_q <= 1'b0; code_q <= '0; phy_q <= '0;
      regad_q <= '0; data_q <= '0; poll_en_q <= 1'b0; poll_phy_q <= '0;
      link_q <= 1'b0; lchg_q <= 1'b0; done_q <= 1'b0;
      lchg_en_q <= 1'b0; done_en_q <= 1'b0;
    end else begin
      if (wr_cmd && !busy_q) begin
        data_q  <= reg_wdata_i[DATA_W-1:0];
        regad_q <= reg_wdata_i[CMD_REG+:ADDR_W];
        phy_q   <= reg_wdata_i[CMD_PHY+:ADDR_W];
        code_q  <= new_code;
        busy_q  <= reg_wdata_i[CMD_START] && ((new_code == OP_WR) || (new_code == OP_RD));
      end
      if (wr_mode) begin
        poll_en_q  <= reg_wdata_i[0];
        poll_phy_q <= reg_wdata_i[1+:ADDR_W];
      end
      if (wr_even) begin
        lchg_en_q <= reg_wdata_i[ST_LCHG];
        done_en_q <= reg_wdata_i[ST_DONE];
      end
      // clear first so that a same-cycle event wins
      if (wr_stat && reg_wdata_i[ST_LCHG]) lchg_q <= 1'b0;
      if (wr_stat && reg_wdata_i[ST_DONE]) done_q <= 1'b0;
      if (f_start) own_host_q <= sel_host;
      if (f_done) begin
        if (own_host_q) begin
          if (code_q == OP_RD) data_q <= f_rdata;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          link_q <= f_rdata[ST_LINK];
          if (f_rdata[ST_LINK] != link_q) lchg_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CMD:  reg_rdata_o = {busy_q, code_q, phy_q, regad_q, data_q};
      RA_MODE: reg_rdata_o = REG_W'({poll_phy_q, poll_en_q});
      RA_STAT: begin
        reg_rdata_o[ST_LCHG] = lchg_q;
        reg_rdata_o[ST_LINK] = link_q;
        reg_rdata_o[ST_DONE] = done_q;
      end
      default: begin
        reg_rdata_o[ST_LCHG] = lchg_en_q;
        reg_rdata_o[ST_DONE] = done_en_q;
      end
    endcase
  end

  assign irq_o = (lchg_en_q && lchg_q) || (done_en_q && done_q);
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o,
  input logic irq_o,
  input logic lchg_clr,
  input logic busy_q,
  input logic f_done,
  input logic f_active,
  input logic own_host_q,
  input logic poll_en_q,
  input logic lchg_q,
  input logic lchg_en_q,
  input logic done_en_q
);
  localparam int LIMIT = (FRAME_LEN + 2) * 2 * CLK_DIV + 8;
  int unsigned stop_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_cnt <= 0;
    else if (f_active && !own_host_q && !poll_en_q) stop_cnt <= stop_cnt + 1;
    else stop_cnt <= 0;
  end

  a_r6_mdio_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o));
  a_r6_oe_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $fell(mdc_o));
  a_r4_busy_ends_with_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(f_done));
  a_r8_lchg_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lchg_q) |-> $past(lchg_clr));
  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lchg_en_q && !done_en_q) |-> !irq_o);
  a_r12_no_new_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(f_active) |-> (own_host_q || $past(poll_en_q)));
  a_r12_stop_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cnt <= LIMIT);
endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mdc_o(mdc_o), .mdio_o(mdio_o),
  .mdio_oe_o(mdio_oe_o), .irq_o(irq_o),
  .lchg_clr(reg_wr_i && (reg_addr_i == 2'd2) && reg_wdata_i[12]),
  .busy_q(busy_q), .f_done(f_done), .f_active(f_active),
  .own_host_q(own_host_q), .poll_en_q(poll_en_q), .lchg_q(lchg_q),
  .lchg_en_q(lchg_en_q), .done_en_q(done_en_q));

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int FRAME_CYC = 64 * 2 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = '0;
  logic [28:0] wdata = '0, rdata;
  logic mdc, mdio_in = 1'b1, mdio_out, oe, irq;

  int vectors = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(oe), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---- clock-by-clock model of MDC phase and MDIO change points (R6)
  int  m_cnt = 0;
  bit  m_mdc = 0, p_mdc = 0, p_mdio = 1, p_oe = 0;
  always @(posedge clk) if (rst_n) begin
    m_cnt++;
    if (m_cnt == DIV) begin m_cnt = 0; m_mdc = !m_mdc; end
  end
  always @(negedge clk) if (rst_n) begin
    chk(mdc == m_mdc, "R6 mdc phase", mdc, m_mdc);
    if (mdio_out != p_mdio || oe != p_oe)
      chk(p_mdc && !mdc, "R6 mdio change off falling mdc", {p_mdc, mdc}, 2'b10);
    p_mdc = mdc; p_mdio = mdio_out; p_oe = oe;
  end

  // ---- behavioural PHY
  logic [15:0] phy_reg [32];
  bit link_up = 1;
  int bitn = 0, nfr = 0;
  logic [63:0] cap, oe_cap;
  logic [15:0] rd_word;
  bit cur_rd = 0;
  int q_phy[$], q_reg[$];

  always @(posedge mdc) begin
    if (bitn != 0 || oe) begin
      cap[63-bitn] = mdio_out;
      oe_cap[63-bitn] = oe;
      bitn++;
      if (bitn == 46) begin
        cur_rd = (cap[29:28] == 2'b10);
        rd_word = (cap[22:18] == 5'd1) ? {13'b0, link_up, 2'b0} : phy_reg[cap[22:18]];
      end
      if (bitn == 64) begin
        bitn = 0;
        chk(cap[63:30] == {32'hFFFF_FFFF, 2'b01}, "R2 preamble/start", cap[63:30], {32'hFFFF_FFFF, 2'b01});
        if (cap[29:28] == 2'b01) begin
          chk(cap[17:16] == 2'b10 && oe_cap == '1, "R2 write ta/oe", {cap[17:16], oe_cap}, {2'b10, 64'hFFFF_FFFF_FFFF_FFFF});
          phy_reg[cap[22:18]] = cap[15:0];
        end else begin
          chk(cap[29:28] == 2'b10, "R3 opcode", cap[29:28], 2'b10);
          chk(oe_cap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R3 oe released", oe_cap, {46'h3FFF_FFFF_FFFF, 18'h0});
        end
        q_phy.push_back(int'(cap[27:23]));
        q_reg.push_back(int'(cap[22:18]));
        nfr++;
      end
    end
  end
  always @(negedge mdc)
    mdio_in = (cur_rd && bitn >= 48 && bitn < 64) ? rd_word[63-bitn] : 1'b1;

  // ---- bus helpers
  task automatic wreg(input logic [1:0] a, input logic [28:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask
  task automatic rreg(input logic [1:0] a, output logic [28:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask
  function automatic logic [28:0] cmd(input int code, input int phy, input int rg, input int data);
    return {1'b1, 2'(code), 5'(phy), 5'(rg), 16'(data)};
  endfunction
  task automatic wait_idle();
    logic [28:0] v;
    for (int i = 0; i < 4000; i++) begin
      rreg(2'd0, v);
      if (!v[28]) return;
    end
    chk(0, "R4 busy never cleared", 1, 0);
  endtask
  task automatic wait_frames(input int n);
    int t = nfr + n;
    while (nfr < t) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [28:0] v;
    int n0, cyc;
    for (int i = 0; i < 32; i++) phy_reg[i] = 16'(i * 16'h0101);
    phy_reg[5] = 16'hA5C3;
    phy_reg[9] = 16'h3C5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(!mdc && !oe && mdio_out && !irq, "R1 pins at reset", {mdc, oe, mdio_out, irq}, 4'b0010);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2/R4 write with a blocked overwrite
    wreg(2'd0, cmd(1, 1, 0, 16'h1000));
    rreg(2'd0, v);
    chk(v[28] == 1, "R4 busy set", v[28], 1);
    repeat (50) @(negedge clk);
    wreg(2'd0, cmd(2, 9, 9, 16'hFFFF));
    rreg(2'd0, v);
    chk(v[28] == 1, "R4 busy mid-frame", v[28], 1);
    wait_idle();
    rreg(2'd0, v);
    chk(v[27:0] == {2'd1, 5'd1, 5'd0, 16'h1000}, "R4 busy write ignored", v[27:0], {2'd1, 5'd1, 5'd0, 16'h1000});
    chk(nfr == 1 && phy_reg[0] == 16'h1000 && q_phy[0] == 1, "R2 write delivered", phy_reg[0], 16'h1000);

    // R9/R10/R8 done flag, gating, w1c
    rreg(2'd2, v);
    chk(v[0] == 1, "R9 done set", v[0], 1);
    chk(irq == 0, "R10 masked irq", irq, 0);
    wreg(2'd3, 29'h1);
    @(negedge clk);
    chk(irq == 1, "R10 done irq", irq, 1);
    wreg(2'd2, 29'h0);
    rreg(2'd2, v);
    chk(v[0] == 1, "R8 write 0 keeps", v[0], 1);
    wreg(2'd2, 29'h1);
    rreg(2'd2, v);
    chk(v[0] == 0 && irq == 0, "R8 w1c done", {v[0], irq}, 0);

    // R3 read
    wreg(2'd0, cmd(2, 3, 5, 16'h0));
    wait_idle();
    rreg(2'd0, v);
    chk(v[15:0] == 16'hA5C3, "R3 read data", v[15:0], 16'hA5C3);
    chk(q_phy[1] == 3 && q_reg[1] == 5, "R3 read header", q_phy[1], 3);
    wreg(2'd2, 29'h1);
    wreg(2'd3, 29'h0);

    // R5 illegal codes
    n0 = nfr;
    wreg(2'd0, cmd(0, 4, 4, 16'h1234));
    rreg(2'd0, v);
    chk(v[28] == 0, "R5 code0 no busy", v[28], 0);
    wreg(2'd0, cmd(3, 4, 4, 16'h1234));
    rreg(2'd0, v);
    chk(v[28] == 0, "R5 code3 no busy", v[28], 0);
    repeat (2 * FRAME_CYC) @(negedge clk);
    chk(nfr == n0, "R5 no frame", nfr, n0);

    // R7 autopoll link tracking
    link_up = 1;
    n0 = nfr;
    wreg(2'd1, {23'b0, 5'd7, 1'b1});
    wait_frames(2);
    chk(q_phy[n0] == 7 && q_reg[n0] == 1, "R7 poll target", {q_phy[n0], q_reg[n0]}, {7, 1});
    rreg(2'd2, v);
    chk(v[12] == 1 && v[2] == 1, "R7 link up seen", {v[12], v[2]}, 2'b11);
    wreg(2'd2, 29'h1000);
    wait_frames(2);
    rreg(2'd2, v);
    chk(v[12] == 0 && v[2] == 1, "R7 no change no flag", {v[12], v[2]}, 2'b01);
    wreg(2'd3, 29'h1000);
    @(negedge clk);
    chk(irq == 0, "R10 enabled but clear", irq, 0);
    link_up = 0;
    wait_frames(2);
    rreg(2'd2, v);
    chk(v[12] == 1 && v[2] == 0, "R7 link down flagged", {v[12], v[2]}, 2'b10);
    chk(irq == 1, "R10 link irq", irq, 1);
    wreg(2'd2, 29'h1000);
    @(negedge clk);
    chk(irq == 0, "R8 w1c link", irq, 0);

    // R11 host preempts next poll
    while (bitn != 20) @(negedge clk);
    n0 = nfr;
    wreg(2'd0, cmd(2, 2, 9, 0));
    wait_idle();
    chk(q_phy[n0] == 7 && q_phy[n0+1] == 2, "R11 host next", q_phy[n0+1], 2);
    rreg(2'd0, v);
    chk(v[15:0] == 16'h3C5A, "R3 read during poll", v[15:0], 16'h3C5A);

    // R12 disable mid-frame
    wait_frames(1);
    while (bitn != 20) @(negedge clk);
    n0 = nfr;
    wreg(2'd1, 29'h0);
    cyc = 0;
    while (nfr == n0 && cyc < 4 * FRAME_CYC) begin @(negedge clk); cyc++; end
    chk(cyc <= (64 + 2) * 2 * DIV + 8, "R12 in-flight bound", cyc, (64 + 2) * 2 * DIV + 8);
    repeat (3 * FRAME_CYC) @(negedge clk);
    chk(nfr == n0 + 1 && oe == 0, "R12 polling stopped", nfr, n0 + 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule